// File: doc/BRIEF.md
# Paged Bank Address Translator

This block sits between a small 8-bit processor and its memories. It turns a 16-bit logical address into a 20-bit physical address through five windows, each aligned to 1 KiB.

Window 0 is hard-wired to the lowest 1 KiB and reads the same offsets of ROM. Windows 1 to 4 are set up through eight byte registers on a separate I/O port. Each register pair holds a boundary, which gives the first logical address of its window, and a base, which is ORed into the logical address.

One physical address bit chooses the device. The low 16 physical bits address ROM or RAM, and only RAM accepts writes. The last register pair is partly locked, so the base of the highest window cannot be changed. The memories themselves are outside the block.

Top module: `pbat_top`

## Requirements
- R1: After reset the registers at I/O offsets 0, 2, 4 and 6 read 0x3F, offsets 1, 3 and 5 read 0x00, and offset 7 reads 0xF0. With these values, every logical address from 0x0400 up is unmapped.
- R2: A write to offsets 0 to 5 stores the byte unchanged, and every offset reads back through `reg_rdata` for the offset on `reg_addr`.
- R3: Offset 7 always reads 0xF0 whatever is written to it. Bits 7:6 of offset 6 are forced to 0 by any write to offset 6 or 7, while a write to offset 6 keeps bits 5:0 as written.
- R4: Window n (n = 1..4) uses boundary B = bits 5:0 of offset 2(n-1). It starts at (B+1)*0x400 and ends one byte below the start of window n+1. Window 4 ends at 0xFFFF. Windows are searched from 1 upward and the first match wins, so a window whose successor starts at or below its own start covers nothing.
- R5: The base of window n is the 10-bit value {offset 2n-1, bits 7:6 of offset 2(n-1)}. The physical address is (base*0x400) bitwise-ORed with the logical address, not added to it.
- R6: Logical 0x0000 to 0x03FF always maps to physical 0x00000 to 0x003FF, and writes there are ignored.
- R7: Physical bit 16 selects the device, 0 for ROM and 1 for RAM. `mem_addr` carries physical bits 15:0, and a write whose physical bit 16 is 0 never raises `ram_we`.
- R8: A read of a logical address that no window covers returns 0xFF, and a write to one is dropped with no memory strobe.
- R9: Translation and read data are combinational in the cycle of the access. A register write becomes visible at the first clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte for `reg_addr` |
| log_rd | input | 1 | Logical read strobe |
| log_wr | input | 1 | Logical write strobe |
| log_addr | input | 16 | Logical address |
| log_wdata | input | 8 | Logical write byte |
| log_rdata | output | 8 | Logical read byte |
| phys_addr | output | 20 | Translated physical address |
| mem_addr | output | 16 | Device address (physical bits 15:0) |
| rom_re | output | 1 | ROM read strobe |
| rom_rdata | input | 8 | ROM read byte |
| ram_re | output | 1 | RAM read strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte |

## Verification
Translation, device strobes and read data are due in the same cycle as the logical access, so the bench drives each access just after a falling edge and samples 2 ns later, before the next rising edge. A register write lands at the next rising edge. The bench checks the old value before that edge and the new value 1 ns after it, and an access issued in the following cycle already sees the new window. RAM writes commit at the rising edge of the access cycle, so their effect is checked by a later read.

// File: rtl/pbat_pkg.sv
package pbat_pkg;
  localparam int LOG_W   = 16;
  localparam int PHY_W   = 20;
  localparam int PAGE_SH = 10;
  localparam int BND_W   = 6;
  localparam int BASE_W  = 10;
  localparam int NUM_WIN = 4;
  localparam int NUM_REG = 2 * NUM_WIN;
  localparam int RADDR_W = $clog2(NUM_REG);
  localparam logic [7:0] LOCK_HI  = 8'hF0;
  localparam logic [7:0] BND_RST  = 8'h3F;

  typedef logic [LOG_W:0] start_t;

  typedef struct packed {
    logic [BND_W-1:0]  bnd;
    logic [BASE_W-1:0] base;
  } win_cfg_t;

  // first logical byte of a programmable window, one bit wider than LOG_W
  function automatic start_t win_start(input logic [BND_W-1:0] b);
    return (start_t'(b) + start_t'(1)) << PAGE_SH;
  endfunction

  // base page ORed onto the logical address
  function automatic logic [PHY_W-1:0] compose(input logic [BASE_W-1:0] a,
                                               input logic [LOG_W-1:0]  la);
    return {a, {PAGE_SH{1'b0}}} | PHY_W'(la);
  endfunction
endpackage

// File: rtl/pbat_regs.sv
module pbat_regs
  import pbat_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [RADDR_W-1:0]  addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  output win_cfg_t [NUM_WIN-1:0] cfg
);
  localparam logic [RADDR_W-1:0] LAST_EVEN = RADDR_W'(NUM_REG - 2);
  localparam logic [RADDR_W-1:0] LAST_ODD  = RADDR_W'(NUM_REG - 1);

  logic [7:0] regs [NUM_REG];
  logic       lock_touch;

  assign lock_touch = we && (addr >= LAST_EVEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REG; i++)
        regs[i] <= (i % 2 == 0) ? BND_RST : ((i == NUM_REG - 1) ? LOCK_HI : 8'h00);
    end else if (we) begin
      if (addr == LAST_ODD) begin
        regs[LAST_ODD]  <= LOCK_HI;
        regs[LAST_EVEN] <= {2'b00, regs[LAST_EVEN][5:0]};
      end else if (addr == LAST_EVEN) begin
        regs[LAST_EVEN] <= {2'b00, wdata[5:0]};
      end else begin
        regs[addr] <= wdata;
      end
    end
  end

  assign rdata = regs[addr];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cfg
    assign cfg[g].bnd  = regs[2*g][BND_W-1:0];
    assign cfg[g].base = {regs[2*g+1], regs[2*g][7:6]};
  end

  assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr < LAST_EVEN) |=> regs[$past(addr)] == $past(wdata));

  assert_odd_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == LAST_ODD) |-> rdata == LOCK_HI);

  assert_even_top_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_touch |=> regs[LAST_EVEN][7:6] == 2'b00);
endmodule

// File: rtl/pbat_decode.sv
module pbat_decode
  import pbat_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  win_cfg_t [NUM_WIN-1:0] cfg,
  input  logic [LOG_W-1:0]       laddr,
  output logic                   hit,
  output logic [PHY_W-1:0]       phys
);
  start_t             st  [NUM_WIN];
  logic [NUM_WIN:0]   raw;
  logic [BASE_W-1:0]  sel_base;
  start_t             la_x;

  assign la_x   = start_t'(laddr);
  assign raw[0] = (laddr[LOG_W-1:PAGE_SH] == '0);

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
    assign st[n] = win_start(cfg[n].bnd);
    if (n == NUM_WIN - 1) begin : g_last
      assign raw[n+1] = (la_x >= st[n]);
    end else begin : g_mid
      assign raw[n+1] = (la_x >= st[n]) && (la_x < st[n+1]);
    end
  end

  // lowest-numbered matching window wins
  always_comb begin
    hit      = 1'b0;
    sel_base = '0;
    for (int n = NUM_WIN; n >= 1; n--) begin
      if (raw[n]) begin
        hit      = 1'b1;
        sel_base = cfg[n-1].base;
      end
    end
    if (raw[0]) begin
      hit      = 1'b1;
      sel_base = '0;
    end
  end

  assign phys = compose(sel_base, laddr);

  assert_fixed_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    raw[0] |-> (hit && phys == PHY_W'(laddr)));

  assert_low_bits_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> phys[LOG_W-1:0] == (laddr | phys[LOG_W-1:0]));
endmodule

// File: rtl/pbat_route.sv
module pbat_route #(
  parameter int         AW        = 16,
  parameter logic [7:0] MISS_DATA = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          log_rd,
  input  logic          log_wr,
  input  logic [7:0]    log_wdata,
  input  logic          hit,
  input  logic          dev_ram,
  input  logic [AW-1:0] dev_addr,
  input  logic [7:0]    rom_rdata,
  input  logic [7:0]    ram_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          rom_re,
  output logic          ram_re,
  output logic          ram_we,
  output logic [7:0]    ram_wdata,
  output logic [7:0]    log_rdata
);
  logic rd_ok, wr_ok;

  assign rd_ok     = log_rd && hit;
  assign wr_ok     = log_wr && hit;
  assign mem_addr  = dev_addr;
  assign rom_re    = rd_ok && !dev_ram;
  assign ram_re    = rd_ok && dev_ram;
  assign ram_we    = wr_ok && dev_ram;
  assign ram_wdata = log_wdata;

  always_comb begin
    if (!hit)         log_rdata = MISS_DATA;
    else if (dev_ram) log_rdata = ram_rdata;
    else              log_rdata = rom_rdata;
  end

  assert_rom_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (log_wr && !dev_ram) |-> !ram_we);

  assert_miss_reads_ff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (log_rd && !hit) |-> (log_rdata == MISS_DATA && !rom_re && !ram_re));

  assert_miss_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (log_wr && !hit) |-> !ram_we);
endmodule

// File: rtl/pbat_top.sv
module pbat_top
  import pbat_pkg::*;
#(
  parameter int         DEVSEL_BIT = 16,
  parameter logic [7:0] MISS_DATA  = 8'hFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               log_rd,
  input  logic               log_wr,
  input  logic [LOG_W-1:0]   log_addr,
  input  logic [7:0]         log_wdata,
  output logic [7:0]         log_rdata,
  output logic [PHY_W-1:0]   phys_addr,
  output logic [LOG_W-1:0]   mem_addr,
  output logic               rom_re,
  input  logic [7:0]         rom_rdata,
  output logic               ram_re,
  output logic               ram_we,
  output logic [7:0]         ram_wdata,
  input  logic [7:0]         ram_rdata
);
  win_cfg_t [NUM_WIN-1:0] cfg;
  logic                   hit;
  logic [PHY_W-1:0]       phys;

  pbat_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  pbat_decode u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .cfg   (cfg),
    .laddr (log_addr),
    .hit   (hit),
    .phys  (phys)
  );

  pbat_route #(.AW(LOG_W), .MISS_DATA(MISS_DATA)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .log_rd    (log_rd),
    .log_wr    (log_wr),
    .log_wdata (log_wdata),
    .hit       (hit),
    .dev_ram   (phys[DEVSEL_BIT]),
    .dev_addr  (phys[LOG_W-1:0]),
    .rom_rdata (rom_rdata),
    .ram_rdata (ram_rdata),
    .mem_addr  (mem_addr),
    .rom_re    (rom_re),
    .ram_re    (ram_re),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .log_rdata (log_rdata)
  );

  assign phys_addr = phys;
endmodule

// File: tb/tb_pbat_top.sv
module tb_pbat_top;
  localparam logic [1:0] OP_RW = 2'd0, OP_RR = 2'd1, OP_LR = 2'd2, OP_LW = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] a;
    logic [7:0]  d;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VECS [NV] = '{
    '{OP_RW, 16'd0, 8'h03}, '{OP_RW, 16'd1, 8'h10}, '{OP_RW, 16'd2, 8'hCF},
    '{OP_RW, 16'd3, 8'h10}, '{OP_RW, 16'd4, 8'h6F}, '{OP_RW, 16'd5, 8'h01},
    '{OP_RW, 16'd6, 8'hF7}, '{OP_RW, 16'd7, 8'h12},
    '{OP_RR, 16'd0, 8'h00}, '{OP_RR, 16'd1, 8'h00}, '{OP_RR, 16'd2, 8'h00},
    '{OP_RR, 16'd3, 8'h00}, '{OP_RR, 16'd4, 8'h00}, '{OP_RR, 16'd5, 8'h00},
    '{OP_RR, 16'd6, 8'h00}, '{OP_RR, 16'd7, 8'h00},
    '{OP_LR, 16'h0010, 8'h00}, '{OP_LR, 16'h0800, 8'h00},
    '{OP_LW, 16'h1234, 8'h5C}, '{OP_LR, 16'h1234, 8'h00},
    '{OP_LW, 16'h4400, 8'h77}, '{OP_LR, 16'h4400, 8'h00},
    '{OP_LR, 16'h8000, 8'h00}, '{OP_LR, 16'h3FFF, 8'h00},
    '{OP_LW, 16'hC010, 8'h99}, '{OP_LR, 16'hC010, 8'h00},
    '{OP_LR, 16'hE123, 8'h00}, '{OP_LR, 16'hFFFF, 8'h00},
    '{OP_LW, 16'hF000, 8'h33}, '{OP_LR, 16'hDFFF, 8'h00},
    '{OP_LW, 16'h0200, 8'h44}, '{OP_LR, 16'h0200, 8'h00},
    '{OP_LW, 16'h0900, 8'h11}, '{OP_LR, 16'h0900, 8'h00},
    '{OP_RW, 16'd2, 8'h02}, '{OP_RW, 16'd3, 8'h20},
    '{OP_LR, 16'h1234, 8'h00}, '{OP_LR, 16'h0C00, 8'h00},
    '{OP_LW, 16'h2000, 8'h66}, '{OP_RW, 16'd6, 8'hC0},
    '{OP_RR, 16'd6, 8'h00}, '{OP_LR, 16'h0400, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        log_rd = 1'b0, log_wr = 1'b0;
  logic [15:0] log_addr = '0;
  logic [7:0]  log_wdata = '0;
  logic [7:0]  log_rdata;
  logic [19:0] phys_addr;
  logic [15:0] mem_addr;
  logic        rom_re, ram_re, ram_we;
  logic [7:0]  rom_rdata, ram_rdata, ram_wdata;

  int checks = 0;
  int errors = 0;

  logic [7:0] sh [8];
  logic [7:0] ram_m  [1024];
  logic [7:0] ram_sh [1024];

  always #4 clk = ~clk;

  pbat_top dut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .log_rd(log_rd), .log_wr(log_wr), .log_addr(log_addr), .log_wdata(log_wdata),
    .log_rdata(log_rdata), .phys_addr(phys_addr), .mem_addr(mem_addr),
    .rom_re(rom_re), .rom_rdata(rom_rdata), .ram_re(ram_re), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // memory models
  assign rom_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'hA5;
  assign ram_rdata = ram_m[mem_addr[9:0]];
  always @(posedge clk) if (ram_we) ram_m[mem_addr[9:0]] <= ram_wdata;

  function automatic int rom_val(input int x);
    return (x & 255) ^ ((x >> 8) & 255) ^ 'hA5;
  endfunction

  function automatic void shadow_reset();
    for (int i = 0; i < 8; i++) sh[i] = (i % 2 == 0) ? 8'h3F : 8'h00;
    sh[7] = 8'hF0;
  endfunction

  // independent model of the window search
  function automatic void xlate(input int a, output bit hit, output int ph, output int win);
    int lo, hi, base;
    hit = 0; ph = 0; win = -1;
    if (a < 'h400) begin hit = 1; ph = a; win = 0; return; end
    for (int w = 1; w <= 4; w++) begin
      lo = (int'(sh[2*w-2] & 8'h3F) + 1) * 1024;
      hi = (w == 4) ? 65536 : (int'(sh[2*w] & 8'h3F) + 1) * 1024;
      if (a >= lo && a < hi) begin
        base = int'(sh[2*w-1]) * 4 + int'(sh[2*w-2]) / 64;
        ph   = (base * 1024) | a;
        hit  = 1; win = w;
        return;
      end
    end
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input int a, input logic [7:0] d);
    bit hit; int ph, win, exp; string req;
    @(negedge clk);
    case (op)
      OP_RW: begin reg_we = 1'b1; reg_addr = a[2:0]; reg_wdata = d; end
      OP_RR: reg_addr = a[2:0];
      OP_LR: begin log_rd = 1'b1; log_addr = a[15:0]; end
      default: begin log_wr = 1'b1; log_addr = a[15:0]; log_wdata = d; end
    endcase
    #2;
    xlate(a, hit, ph, win);
    case (op)
      OP_RR: chk((a >= 6) ? "R3 lock readback" : "R2 readback", int'(reg_rdata), int'(sh[a]));
      OP_LR: begin
        if (!hit) begin
          req = "R8 miss read"; exp = 'hFF;
        end else if (ph[16] == 1'b0) begin
          req = (win == 0) ? "R6 fixed window read" : "R7 rom read";
          exp = rom_val(ph & 'hFFFF);
        end else begin
          req = "R4 ram window read"; exp = int'(ram_sh[ph & 1023]);
        end
        chk(req, int'(log_rdata), exp);
        if (hit) begin
          chk("R5 physical address", int'(phys_addr), ph);
          chk("R7 device address", int'(mem_addr), ph & 'hFFFF);
          chk("R7 ram strobe", int'(ram_re), ph[16]);
        end else begin
          chk("R8 no strobe on miss", int'(rom_re | ram_re), 0);
        end
      end
      OP_LW: begin
        req = !hit ? "R8 miss write" : (win == 0) ? "R6 fixed window write" : "R7 write select";
        chk(req, int'(ram_we), (hit && ph[16]) ? 1 : 0);
      end
      default: ;
    endcase
    @(posedge clk);
    #1;
    if (op == OP_RW) begin
      if (a == 7) begin sh[7] = 8'hF0; sh[6] = sh[6] & 8'h3F; end
      else if (a == 6) sh[6] = d & 8'h3F;
      else sh[a] = d;
    end
    if (op == OP_LW && hit && ph[16]) ram_sh[ph & 1023] = d;
    reg_we = 1'b0; log_rd = 1'b0; log_wr = 1'b0;
  endtask

  task automatic check_defaults(input string tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      reg_addr = i[2:0];
      #2;
      chk(tag, int'(reg_rdata), (i == 7) ? 'hF0 : (i % 2 == 0) ? 'h3F : 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin ram_m[i] = 8'h00; ram_sh[i] = 8'h00; end
    shadow_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: defaults and all-unmapped state
    check_defaults("R1 reset value");
    run_op(OP_LR, 'h2000, 8'h00);
    run_op(OP_LR, 'hFFFF, 8'h00);
    run_op(OP_LR, 'h03FF, 8'h00);

    // vector table
    for (int v = 0; v < NV; v++) run_op(VECS[v].op, int'(VECS[v].a), VECS[v].d);

    // R9: register write lands at the next edge, visible to the very next access
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h07;
    #2 chk("R9 old value before edge", int'(reg_rdata), int'(sh[0]));
    @(posedge clk);
    #1 chk("R9 new value after edge", int'(reg_rdata), 'h07);
    sh[0] = 8'h07;
    reg_we = 1'b0;
    run_op(OP_LR, 'h2000, 8'h00);
    run_op(OP_LR, 'h1FFF, 8'h00);

    // R4: empty window when the next boundary is lower
    run_op(OP_RW, 4, 8'h01);
    run_op(OP_LR, 'h0900, 8'h00);
    run_op(OP_LR, 'h0C00, 8'h00);

    // R1: reset in mid-run restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    shadow_reset();
    check_defaults("R1 reset after use");
    run_op(OP_LR, 'h8000, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule